// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block is a one-byte mailbox through which a running CPU hands data to an external debugger. The CPU writes a byte to one I/O address. The block keeps that byte and raises a dirty flag. The flag stays up until the debugger reports, through a read strobe, that it has collected the byte. When the CPU reads the same address, the low seven bits come from the stored byte. The top bit is the live dirty flag, so software can tell whether the debugger has drained the mailbox.

The mailbox address is also the address of an ordinary peripheral register. The CPU reaches the mailbox only when two conditions hold: the debug-enable fuse is programmed, and the debugger has raised its access-enable. In every other case the block passes reads and writes on to the ordinary register through a pair of strobes. The block also holds two small combinational guards. One refuses a request to program the debug-enable fuse while any lock bit is set. The other reports that the debug port is active only when its enable fuse is set and the CPU-controlled disable bit is clear.

Top module: `dbg_mailbox`

## Requirements
- R1: A CPU write to the shared address while mailbox access is enabled stores `cpu_wdata`. The byte appears on `dbg_data`, and `dbg_dirty` reads 1, from the clock edge that takes the write.
- R2: A CPU read of the shared address while mailbox access is enabled returns the stored bits 6..0 on `cpu_rdata[6:0]` and the dirty flag on `cpu_rdata[7]`, in the same cycle.
- R3: A cycle with `dbg_rd_ack` high and no enabled CPU write clears `dbg_dirty` at the next edge and leaves the stored byte unchanged.
- R4: Mailbox access is enabled only when `fuse_dbg_en` and `dbg_acc_en` are both 1. Otherwise a write to the shared address pulses `io_wr`, and a read pulses `io_rd` and returns `io_rdata`. An access to any other address raises neither strobe and returns 0.
- R5: After reset, or after reset is asserted mid-operation, the stored byte and the dirty flag are all zero.
- R6: `fuse_prog_ok` is 1 only when `fuse_prog_req` is 1 and both bits of `lock_set` are 0 (a 1 bit means that lock bit is programmed).
- R7: `port_active` is 1 exactly when `port_fuse_en` is 1 and `port_disable` is 0.
- R8: When an enabled CPU write and `dbg_rd_ack` fall in the same cycle, the write wins: the new byte is stored and `dbg_dirty` ends at 1.
- R9: `dbg_data` always shows all eight stored bits, whatever the access-enable and fuse inputs are.
- R10: While mailbox access is disabled, a write to the shared address leaves `dbg_data` and `dbg_dirty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU I/O address |
| cpu_wr | input | 1 | CPU write enable |
| cpu_rd | input | 1 | CPU read enable |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data (combinational) |
| io_wr | output | 1 | Write strobe to the ordinary register |
| io_rd | output | 1 | Read strobe to the ordinary register |
| io_rdata | input | DATA_W | Read data from the ordinary register |
| fuse_dbg_en | input | 1 | Debug-enable fuse is programmed |
| dbg_acc_en | input | 1 | Debugger grants mailbox access |
| dbg_rd_ack | input | 1 | Debugger has collected the byte |
| dbg_data | output | DATA_W | Stored byte for the debugger |
| dbg_dirty | output | 1 | Uncollected byte pending |
| fuse_prog_req | input | 1 | Request to program the debug-enable fuse |
| lock_set | input | 2 | Lock bits, 1 = programmed |
| fuse_prog_ok | output | 1 | Fuse programming request accepted |
| port_fuse_en | input | 1 | Debug-port enable fuse |
| port_disable | input | 1 | CPU-controlled port disable bit |
| port_active | output | 1 | Debug port is active |

## Verification
Two events can land in the same cycle: a CPU write that sets the dirty flag, and a debugger acknowledge that clears it. The bench drives both in one cycle with a fresh byte. After the edge it expects the new byte on `dbg_data` and the flag still set. A second pairing puts a CPU read on the same cycle as the acknowledge. That read must return the flag as it stood before the edge, and the flag must then read 0 on the next cycle.

// File: rtl/dbg_mailbox_pkg.sv
// Package: shared sizes and the decoded access kind for the debug mailbox.
package dbg_mailbox_pkg;
    localparam int MB_DATA_W = 8;
    localparam int MB_ADDR_W = 6;
    localparam int MB_LOCK_N = 2;

    // Where a CPU access to the shared address is routed.
    typedef enum logic [1:0] {
        ROUTE_NONE    = 2'd0,
        ROUTE_MAILBOX = 2'd1,
        ROUTE_IO      = 2'd2
    } route_e;
endpackage

// File: rtl/mb_store.sv
// Module: mb_store
// Holds the mailbox byte and its dirty flag.
// Assumes: wr_en and clr are single-cycle qualified strobes; a write wins over a clear.
module mb_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    output logic [DATA_W-1:0] data_q,
    output logic              dirty_q
);
    // Capture the byte on an enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (wr_en)
            data_q <= wdata;
    end

    // Set on write, clear on debugger acknowledge; the write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dirty_q <= 1'b0;
        else if (wr_en)
            dirty_q <= 1'b1;
        else if (clr)
            dirty_q <= 1'b0;
    end
endmodule

// File: rtl/mb_steer.sv
// Module: mb_steer
// Decodes the shared address and routes each access to the mailbox or to the ordinary register.
// Assumes: the read path is combinational; the top bit of a mailbox read is the dirty flag.
module mb_steer
    import dbg_mailbox_pkg::*;
#(
    parameter int                ADDR_W  = 6,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] MB_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              fuse_en,
    input  logic              acc_en,
    input  logic [DATA_W-1:0] mb_data,
    input  logic              mb_dirty,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              mb_wr,
    output logic              io_wr,
    output logic              io_rd,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_BIT = DATA_W - 1;

    route_e route;

    // Choose the target of an access from the address and the two enables.
    always_comb begin
        if (addr != MB_ADDR)
            route = ROUTE_NONE;
        else if (fuse_en && acc_en)
            route = ROUTE_MAILBOX;
        else
            route = ROUTE_IO;
    end

    // Raise the strobes for the chosen target.
    always_comb begin
        mb_wr = wr && (route == ROUTE_MAILBOX);
        io_wr = wr && (route == ROUTE_IO);
        io_rd = rd && (route == ROUTE_IO);
    end

    // Build the read data: the dirty flag overlays the top bit of the mailbox byte.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (route)
                ROUTE_MAILBOX: rdata = {mb_dirty, mb_data[FLAG_BIT-1:0]};
                ROUTE_IO:      rdata = io_rdata;
                default:       rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mb_guard.sv
// Module: mb_guard
// Combinational protection checks: gates debug-fuse programming on the lock bits
// and derives the debug-port enable.
// Assumes: a lock bit at 1 means that lock is programmed.
module mb_guard #(
    parameter int LOCK_N = 2
) (
    input  logic              prog_req,
    input  logic [LOCK_N-1:0] lock_set,
    input  logic              port_fuse_en,
    input  logic              port_disable,
    output logic              prog_ok,
    output logic              port_active
);
    logic [LOCK_N:0] lock_any;

    assign lock_any[0] = 1'b0;

    // Fold each lock bit into a running "any lock programmed" chain.
    for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
        assign lock_any[i+1] = lock_any[i] | lock_set[i];
    end

    // Accept programming only with no lock set; the port needs its fuse and no disable.
    always_comb begin
        prog_ok     = prog_req && !lock_any[LOCK_N];
        port_active = port_fuse_en && !port_disable;
    end
endmodule

// File: rtl/dbg_mailbox.sv
// Module: dbg_mailbox (top)
// One-byte CPU-to-debugger mailbox with a dirty flag, overlaid on an ordinary I/O address.
// Assumes: synchronous active-low reset; the CPU read path is combinational.
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int                ADDR_W  = MB_ADDR_W,
    parameter int                DATA_W  = MB_DATA_W,
    parameter int                LOCK_N  = MB_LOCK_N,
    parameter logic [ADDR_W-1:0] MB_ADDR = 6'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_wr,
    output logic              io_rd,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              fuse_dbg_en,
    input  logic              dbg_acc_en,
    input  logic              dbg_rd_ack,
    output logic [DATA_W-1:0] dbg_data,
    output logic              dbg_dirty,
    input  logic              fuse_prog_req,
    input  logic [LOCK_N-1:0] lock_set,
    output logic              fuse_prog_ok,
    input  logic              port_fuse_en,
    input  logic              port_disable,
    output logic              port_active
);
    logic mb_wr;

    mb_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MB_ADDR(MB_ADDR)) u_steer (
        .addr     (cpu_addr),
        .wr       (cpu_wr),
        .rd       (cpu_rd),
        .fuse_en  (fuse_dbg_en),
        .acc_en   (dbg_acc_en),
        .mb_data  (dbg_data),
        .mb_dirty (dbg_dirty),
        .io_rdata (io_rdata),
        .mb_wr    (mb_wr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .rdata    (cpu_rdata)
    );

    mb_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mb_wr),
        .wdata   (cpu_wdata),
        .clr     (dbg_rd_ack),
        .data_q  (dbg_data),
        .dirty_q (dbg_dirty)
    );

    mb_guard #(.LOCK_N(LOCK_N)) u_guard (
        .prog_req     (fuse_prog_req),
        .lock_set     (lock_set),
        .port_fuse_en (port_fuse_en),
        .port_disable (port_disable),
        .prog_ok      (fuse_prog_ok),
        .port_active  (port_active)
    );
endmodule

// File: rtl/dbg_mailbox_chk.sv
// Module: dbg_mailbox_chk
// Property checker bound to dbg_mailbox; sees only its ports.
module dbg_mailbox_chk #(
    parameter int                ADDR_W  = 6,
    parameter int                DATA_W  = 8,
    parameter int                LOCK_N  = 2,
    parameter logic [ADDR_W-1:0] MB_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              io_wr,
    input logic              io_rd,
    input logic              fuse_dbg_en,
    input logic              dbg_acc_en,
    input logic              dbg_rd_ack,
    input logic [DATA_W-1:0] dbg_data,
    input logic              dbg_dirty,
    input logic [LOCK_N-1:0] lock_set,
    input logic              fuse_prog_ok,
    input logic              port_fuse_en,
    input logic              port_disable,
    input logic              port_active
);
    logic hit, en;
    assign hit = (cpu_addr == MB_ADDR);
    assign en  = fuse_dbg_en && dbg_acc_en;

    AST_WR_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && en && cpu_wr) |=> dbg_dirty);  // R8
    AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && en && cpu_wr) |=> (dbg_data == $past(cpu_wdata)));  // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd_ack && !(hit && en && cpu_wr)) |=> (!dbg_dirty && $stable(dbg_data)));  // R3
    AST_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !en && !dbg_rd_ack) |=> ($stable(dbg_data) && $stable(dbg_dirty)));  // R10
    AST_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && hit && en) |-> (cpu_rdata[DATA_W-1] == dbg_dirty));  // R2
    AST_IO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || io_rd) |-> (hit && !en));  // R4
    AST_FUSE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_prog_ok |-> (lock_set == '0));  // R6
    AST_PORT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        port_active |-> (port_fuse_en && !port_disable));  // R7
endmodule

bind dbg_mailbox dbg_mailbox_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_N(LOCK_N), .MB_ADDR(MB_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .io_wr(io_wr), .io_rd(io_rd),
    .fuse_dbg_en(fuse_dbg_en), .dbg_acc_en(dbg_acc_en), .dbg_rd_ack(dbg_rd_ack),
    .dbg_data(dbg_data), .dbg_dirty(dbg_dirty), .lock_set(lock_set),
    .fuse_prog_ok(fuse_prog_ok), .port_fuse_en(port_fuse_en),
    .port_disable(port_disable), .port_active(port_active)
);

// File: tb/sim_dbg_mailbox.sv
module sim_dbg_mailbox;
    localparam logic [5:0] MBA = 6'h31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cpu_addr = MBA;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata, io_rdata = '0, dbg_data;
    logic       io_wr, io_rd, fuse_dbg_en = 1'b0, dbg_acc_en = 1'b0, dbg_rd_ack = 1'b0, dbg_dirty;
    logic       fuse_prog_req = 1'b0, fuse_prog_ok, port_fuse_en = 1'b0, port_disable = 1'b0, port_active;
    logic [1:0] lock_set = '0;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbg_mailbox u0 (.*);

    // Row: fuse acc wr rd ack | wdata | io_rdata | exp cpu_rdata | exp dbg_data | exp dirty
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {5'b11100, 8'hA5, 8'h00, 8'h00, 8'hA5, 1'b1},  // R1 write
        {5'b11010, 8'h00, 8'h00, 8'hA5, 8'hA5, 1'b1},  // R2 read, flag set
        {5'b11001, 8'h00, 8'h00, 8'h00, 8'hA5, 1'b0},  // R3 ack
        {5'b11010, 8'h00, 8'h00, 8'h25, 8'hA5, 1'b0},  // R2 read, flag clear
        {5'b01100, 8'h3C, 8'h5A, 8'h00, 8'hA5, 1'b0},  // R10 no fuse
        {5'b10010, 8'h00, 8'h5A, 8'h5A, 8'hA5, 1'b0},  // R4 io read
        {5'b11101, 8'h7F, 8'h00, 8'h00, 8'h7F, 1'b1},  // R8 write+ack
        {5'b11010, 8'h00, 8'h00, 8'hFF, 8'h7F, 1'b1},  // R2
        {5'b00010, 8'h00, 8'hC3, 8'hC3, 8'h7F, 1'b1},  // R4 io read
        {5'b11100, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1},  // R9 full byte
        {5'b11011, 8'h00, 8'h00, 8'h80, 8'h80, 1'b0},  // R3 read+ack
        {5'b11010, 8'h00, 8'h00, 8'h00, 8'h80, 1'b0}   // R2
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; dbg_rd_ack = 0; cpu_addr = MBA;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R5 reset state
        chk("R5 data", dbg_data, 8'h00);
        chk("R5 dirty", {7'b0, dbg_dirty}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {fuse_dbg_en, dbg_acc_en, cpu_wr, cpu_rd, dbg_rd_ack} = VEC[i][37:33];
            cpu_wdata = VEC[i][32:25];
            io_rdata  = VEC[i][24:17];
            #2;
            chk("R2/R4 rdata", cpu_rdata, VEC[i][16:9]);
            @(negedge clk);
            chk("R1/R9 dbg_data", dbg_data, VEC[i][8:1]);
            chk("R3/R8 dirty", {7'b0, dbg_dirty}, {7'b0, VEC[i][0]});
            idle();
        end

        // R4 write strobe when access is disabled
        fuse_dbg_en = 1; dbg_acc_en = 0; cpu_wr = 1; cpu_wdata = 8'h11; #2;
        chk("R4 io_wr", {7'b0, io_wr}, 8'h01);
        @(negedge clk); idle();
        chk("R10 data kept", dbg_data, 8'h80);
        // R4 other address: no strobes, zero read, no change
        dbg_acc_en = 1; cpu_addr = 6'h12; cpu_wr = 1; cpu_rd = 1; io_rdata = 8'hEE; #2;
        chk("R4 no strobe", {6'b0, io_wr, io_rd}, 8'h00);
        chk("R4 zero read", cpu_rdata, 8'h00);
        @(negedge clk); idle();
        chk("R4 other addr", dbg_data, 8'h80);

        // R6 fuse programming gate
        fuse_prog_req = 1;
        for (int l = 0; l < 4; l++) begin
            lock_set = l[1:0]; #2;
            chk("R6 prog_ok", {7'b0, fuse_prog_ok}, {7'b0, l == 0});
        end
        fuse_prog_req = 0; lock_set = 0; #2;
        chk("R6 no req", {7'b0, fuse_prog_ok}, 8'h00);

        // R7 port enable
        for (int p = 0; p < 4; p++) begin
            {port_fuse_en, port_disable} = p[1:0]; #2;
            chk("R7 port_active", {7'b0, port_active}, {7'b0, p == 2});
        end

        // R5 reset mid-operation
        @(negedge clk);
        cpu_wr = 1; cpu_wdata = 8'h6B;
        @(negedge clk); idle();
        chk("R1 pre-reset", dbg_data, 8'h6B);
        rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R5 data", dbg_data, 8'h00);
        chk("R5 dirty", {7'b0, dbg_dirty}, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule